// File: doc/BRIEF.md
# Tag-Wakeup Reservation Station Array

This block is a small pool of scheduling slots that sits between the rename stage and one execution unit. Each dispatched operation brings an opcode, a destination tag and two source operands. Each source is either a value that is already known or the tag of the operation that will produce it. A slot with a pending source watches a single result broadcast bus. When the bus carries the tag the slot is waiting for, the slot copies the broadcast value into its own storage and marks that source as resolved. No register file is read.

When both sources of a slot are resolved, the slot competes to issue. The lowest-numbered ready slot is presented on a valid/ready issue port. The slot is released once the handshake completes. Tag value zero is reserved and means "value present". A synchronous flush empties the whole pool.

Top module: `tag_wakeup_sched`

## Requirements
- R1: After reset no slot is occupied: `iss_valid` is 0 and `dsp_ready` is 1.
- R2: An operation is taken in when `dsp_valid` and `dsp_ready` are both 1. It goes into the lowest-numbered empty slot. `dsp_ready` is 0 when all N_ENT slots are occupied, and also while `flush` is 1.
- R3: A source tag of 0 at dispatch means the accompanying value is valid. An operation dispatched with both tags 0 shows `iss_valid` = 1 in the next cycle.
- R4: A slot is offered for issue only when neither of its sources is pending. `iss_op`, `iss_a`, `iss_b` and `iss_dst` carry the opcode, the captured source values and the destination tag of that slot.
- R5: A broadcast with `bc_valid` = 1 and a nonzero `bc_tag` equal to the pending tag of a source causes that source to store `bc_val` and become resolved. Each source of each slot is matched on its own, so one broadcast may resolve both sources of one slot, and sources in several slots.
- R6: If a broadcast arrives in the same cycle as the dispatch of an operation whose source tag equals `bc_tag`, that source is stored as resolved with `bc_val`.
- R7: A broadcast with `bc_valid` = 0, or with `bc_tag` = 0, changes no slot. A slot that is waiting stays not-ready.
- R8: When several slots are ready, the lowest-numbered one is offered. A lower slot that becomes ready while a higher one is being offered takes over the issue port.
- R9: A slot is released when `iss_valid` and `iss_ready` are both 1 at a clock edge. While `iss_ready` is 0 and nothing else changes, the offered operation holds.
- R10: `flush` = 1 empties every slot at the next edge and drops a dispatch in the same cycle. While `flush` is 1, `iss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| dsp_valid | input | 1 | Dispatch request |
| dsp_ready | output | 1 | A slot is free and dispatch is accepted |
| dsp_op | input | OP_W | Opcode of dispatched operation |
| dsp_a_tag | input | TAG_W | Producer tag of source A, 0 = value present |
| dsp_a_val | input | DATA_W | Value of source A when its tag is 0 |
| dsp_b_tag | input | TAG_W | Producer tag of source B, 0 = value present |
| dsp_b_val | input | DATA_W | Value of source B when its tag is 0 |
| dsp_dst | input | TAG_W | Destination tag of dispatched operation |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | A ready operation is offered |
| iss_ready | input | 1 | Execution unit accepts the offered operation |
| iss_op | output | OP_W | Opcode of offered operation |
| iss_a | output | DATA_W | Source A value of offered operation |
| iss_b | output | DATA_W | Source B value of offered operation |
| iss_dst | output | TAG_W | Destination tag of offered operation |

## Verification
The properties assume that reset is held for at least one edge before any traffic. They also assume that the dispatch and broadcast inputs carry known values whenever their valid is high. Occupancy properties count occupied slots around each edge and rely on accepted dispatches and completed issues being the only events that change that count outside a flush. The stimulus drives every input after the falling edge and holds it through the rising edge. It sends no unknown values, and it mixes zero and nonzero tags so that slots both wait and wake. It also issues occasional flushes, which clear slots stuck on tags that are never broadcast.

// File: rtl/tws_pkg.sv
package tws_pkg;

   // Reserved producer tag: the operand value is already present.
   localparam int TAG_NONE = 0;

   // Implementation variants of the priority picker.
   typedef enum int {
      PICK_LOOP = 0,   // linear scan, first set bit wins
      PICK_TWOS = 1    // isolate lowest set bit with x & -x
   } pick_style_e;

endpackage

// File: rtl/tws_operand.sv
module tws_operand #(
   parameter int TAG_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              live,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              pending,
   output logic [DATA_W-1:0] val_q
);

   localparam logic [TAG_W-1:0] NULL_TAG = TAG_W'(tws_pkg::TAG_NONE);

   logic [TAG_W-1:0] tag_q;
   logic             bc_live;
   logic             hit_new;
   logic             hit_old;

   assign bc_live = bc_valid && (bc_tag != NULL_TAG);
   assign hit_new = bc_live && (in_tag == bc_tag);
   assign hit_old = bc_live && live && (tag_q == bc_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= NULL_TAG;
         val_q <= '0;
      end else if (load) begin
         if (hit_new) begin
            tag_q <= NULL_TAG;
            val_q <= bc_val;
         end else begin
            tag_q <= in_tag;
            val_q <= in_val;
         end
      end else if (hit_old) begin
         tag_q <= NULL_TAG;
         val_q <= bc_val;
      end
   end

   assign pending = (tag_q != NULL_TAG);

endmodule

// File: rtl/tws_slot.sv
module tws_slot #(
   parameter int OP_W   = 4,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              load,
   input  logic              release_i,
   input  logic [OP_W-1:0]   in_op,
   input  logic [TAG_W-1:0]  in_a_tag,
   input  logic [DATA_W-1:0] in_a_val,
   input  logic [TAG_W-1:0]  in_b_tag,
   input  logic [DATA_W-1:0] in_b_val,
   input  logic [TAG_W-1:0]  in_dst,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              busy,
   output logic              ready,
   output logic [OP_W-1:0]   op_q,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] b_q,
   output logic [TAG_W-1:0]  dst_q
);

   logic a_pend;
   logic b_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (flush) begin
         busy <= 1'b0;
      end else if (load) begin
         busy <= 1'b1;
      end else if (release_i) begin
         busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         dst_q <= '0;
      end else if (load) begin
         op_q  <= in_op;
         dst_q <= in_dst;
      end
   end

   tws_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .live     (busy),
      .in_tag   (in_a_tag),
      .in_val   (in_a_val),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .pending  (a_pend),
      .val_q    (a_q)
   );

   tws_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .live     (busy),
      .in_tag   (in_b_tag),
      .in_val   (in_b_val),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .pending  (b_pend),
      .val_q    (b_q)
   );

   assign ready = busy && !a_pend && !b_pend;

endmodule

// File: rtl/tws_pick.sv
module tws_pick import tws_pkg::*; #(
   parameter int          N     = 4,
   parameter pick_style_e STYLE = PICK_LOOP
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   generate
      if (STYLE == PICK_TWOS) begin : g_twos
         assign grant = req & (~req + N'(1));
      end else begin : g_loop
         always_comb begin
            logic found;
            found = 1'b0;
            grant = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !found) begin
                  grant[i] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign any = |req;

endmodule

// File: rtl/tag_wakeup_sched.sv
module tag_wakeup_sched import tws_pkg::*; #(
   parameter int          N_ENT      = 4,
   parameter int          TAG_W      = 3,
   parameter int          DATA_W     = 16,
   parameter int          OP_W       = 4,
   parameter pick_style_e PICK_STYLE = PICK_LOOP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              dsp_valid,
   output logic              dsp_ready,
   input  logic [OP_W-1:0]   dsp_op,
   input  logic [TAG_W-1:0]  dsp_a_tag,
   input  logic [DATA_W-1:0] dsp_a_val,
   input  logic [TAG_W-1:0]  dsp_b_tag,
   input  logic [DATA_W-1:0] dsp_b_val,
   input  logic [TAG_W-1:0]  dsp_dst,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [OP_W-1:0]   iss_op,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b,
   output logic [TAG_W-1:0]  iss_dst
);

   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   generate
      if (N_ENT < 2) begin : g_chk_n
         $error("tag_wakeup_sched: N_ENT must be at least 2");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("tag_wakeup_sched: TAG_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_chk_data
         $error("tag_wakeup_sched: DATA_W must be at least 1");
      end
      if (OP_W < 1) begin : g_chk_op
         $error("tag_wakeup_sched: OP_W must be at least 1");
      end
   endgenerate

   logic [N_ENT-1:0]  busy_vec;
   logic [N_ENT-1:0]  ready_vec;
   logic [N_ENT-1:0]  free_gnt;
   logic [N_ENT-1:0]  iss_gnt;
   logic [N_ENT-1:0]  load_vec;
   logic [N_ENT-1:0]  rel_vec;
   logic              free_any;
   logic              rdy_any;
   logic              dsp_fire;
   logic              iss_fire;
   logic [IDX_W-1:0]  iss_idx;

   logic [OP_W-1:0]   op_arr  [N_ENT];
   logic [DATA_W-1:0] a_arr   [N_ENT];
   logic [DATA_W-1:0] b_arr   [N_ENT];
   logic [TAG_W-1:0]  dst_arr [N_ENT];

   tws_pick #(.N(N_ENT), .STYLE(PICK_STYLE)) u_pick_free (
      .req   (~busy_vec),
      .grant (free_gnt),
      .any   (free_any)
   );

   tws_pick #(.N(N_ENT), .STYLE(PICK_STYLE)) u_pick_issue (
      .req   (ready_vec),
      .grant (iss_gnt),
      .any   (rdy_any)
   );

   assign dsp_ready = free_any && !flush;
   assign iss_valid = rdy_any && !flush;
   assign dsp_fire  = dsp_valid && dsp_ready;
   assign iss_fire  = iss_valid && iss_ready;
   assign load_vec  = free_gnt & {N_ENT{dsp_fire}};
   assign rel_vec   = iss_gnt & {N_ENT{iss_fire}};

   genvar gi;
   generate
      for (gi = 0; gi < N_ENT; gi++) begin : g_slot
         tws_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .load      (load_vec[gi]),
            .release_i (rel_vec[gi]),
            .in_op     (dsp_op),
            .in_a_tag  (dsp_a_tag),
            .in_a_val  (dsp_a_val),
            .in_b_tag  (dsp_b_tag),
            .in_b_val  (dsp_b_val),
            .in_dst    (dsp_dst),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_val    (bc_val),
            .busy      (busy_vec[gi]),
            .ready     (ready_vec[gi]),
            .op_q      (op_arr[gi]),
            .a_q       (a_arr[gi]),
            .b_q       (b_arr[gi]),
            .dst_q     (dst_arr[gi])
         );
      end
   endgenerate

   always_comb begin
      iss_idx = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (iss_gnt[i]) iss_idx = iss_idx | IDX_W'(i);
      end
   end

   assign iss_op  = op_arr[iss_idx];
   assign iss_a   = a_arr[iss_idx];
   assign iss_b   = b_arr[iss_idx];
   assign iss_dst = dst_arr[iss_idx];

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
   parameter int N_ENT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             dsp_valid,
   input logic             dsp_ready,
   input logic             iss_valid,
   input logic             iss_ready,
   input logic [N_ENT-1:0] busy_vec
);

   AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> (busy_vec == '0));                               // R1

   AST_DISPATCH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && dsp_ready && !(iss_valid && iss_ready))
      |=> ($countones(busy_vec) == $countones($past(busy_vec)) + 1));   // R2

   AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec == '0 && !flush) |-> dsp_ready);                        // R2

   AST_ISSUE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (busy_vec != '0));                                  // R4

   AST_HANDSHAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && !(dsp_valid && dsp_ready))
      |=> ($countones(busy_vec) == $countones($past(busy_vec)) - 1));   // R9

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (busy_vec == '0));                                      // R10

   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!iss_valid && !dsp_ready));                            // R10

endmodule

bind tag_wakeup_sched tws_checker #(.N_ENT(N_ENT)) u_tws_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .dsp_valid (dsp_valid),
   .dsp_ready (dsp_ready),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .busy_vec  (busy_vec)
);

// File: tb/tag_wakeup_sched_test.sv
module tag_wakeup_sched_test;

   localparam int N   = 4;
   localparam int TW  = 3;
   localparam int DW  = 16;
   localparam int OW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          dsp_valid = 1'b0;
   logic          dsp_ready;
   logic [OW-1:0] dsp_op = '0;
   logic [TW-1:0] dsp_a_tag = '0;
   logic [DW-1:0] dsp_a_val = '0;
   logic [TW-1:0] dsp_b_tag = '0;
   logic [DW-1:0] dsp_b_val = '0;
   logic [TW-1:0] dsp_dst = '0;
   logic          bc_valid = 1'b0;
   logic [TW-1:0] bc_tag = '0;
   logic [DW-1:0] bc_val = '0;
   logic          iss_valid;
   logic          iss_ready = 1'b0;
   logic [OW-1:0] iss_op;
   logic [DW-1:0] iss_a;
   logic [DW-1:0] iss_b;
   logic [TW-1:0] iss_dst;

   always #10 clk = ~clk;

   tag_wakeup_sched #(.N_ENT(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
      .dsp_a_tag(dsp_a_tag), .dsp_a_val(dsp_a_val),
      .dsp_b_tag(dsp_b_tag), .dsp_b_val(dsp_b_val), .dsp_dst(dsp_dst),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
      .iss_a(iss_a), .iss_b(iss_b), .iss_dst(iss_dst)
   );

   // Behavioural reference: one record per occupied slot position.
   int    m_busy [N];
   int    m_op   [N];
   int    m_qa   [N];
   int    m_qb   [N];
   int    m_va   [N];
   int    m_vb   [N];
   int    m_dst  [N];
   int    n_cmp  = 0;
   int    n_bad  = 0;
   string cur_req = "R1";
   bit    done = 0;

   function automatic int first_free();
      for (int i = 0; i < N; i++) if (m_busy[i] == 0) return i;
      return -1;
   endfunction

   function automatic int first_ready();
      for (int i = 0; i < N; i++)
         if (m_busy[i] != 0 && m_qa[i] == 0 && m_qb[i] == 0) return i;
      return -1;
   endfunction

   task automatic check(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0d exp=%0d @%0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      int e_rdy;
      int e_iv;
      int r;
      e_rdy = (!flush && first_free() >= 0) ? 1 : 0;
      r     = first_ready();
      e_iv  = (!flush && r >= 0) ? 1 : 0;
      check("dsp_ready", int'(dsp_ready), e_rdy);
      check("iss_valid", int'(iss_valid), e_iv);
      if (e_iv != 0) begin
         check("iss_op",  int'(iss_op),  m_op[r]);
         check("iss_a",   int'(iss_a),   m_va[r]);
         check("iss_b",   int'(iss_b),   m_vb[r]);
         check("iss_dst", int'(iss_dst), m_dst[r]);
      end
   endtask

   task automatic model_step();
      int f;
      int r;
      int t;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) m_busy[i] = 0;
         return;
      end
      if (flush) begin
         for (int i = 0; i < N; i++) m_busy[i] = 0;
         return;
      end
      f = first_free();
      r = first_ready();
      if (r >= 0 && iss_ready) m_busy[r] = 0;
      t = int'(bc_tag);
      if (bc_valid && t != 0) begin
         for (int i = 0; i < N; i++) begin
            if (m_busy[i] != 0 && m_qa[i] == t) begin m_qa[i] = 0; m_va[i] = int'(bc_val); end
            if (m_busy[i] != 0 && m_qb[i] == t) begin m_qb[i] = 0; m_vb[i] = int'(bc_val); end
         end
      end
      if (dsp_valid && f >= 0) begin
         m_busy[f] = 1;
         m_op[f]   = int'(dsp_op);
         m_dst[f]  = int'(dsp_dst);
         m_qa[f]   = int'(dsp_a_tag);
         m_va[f]   = int'(dsp_a_val);
         m_qb[f]   = int'(dsp_b_tag);
         m_vb[f]   = int'(dsp_b_val);
         if (bc_valid && t != 0 && m_qa[f] == t) begin m_qa[f] = 0; m_va[f] = int'(bc_val); end
         if (bc_valid && t != 0 && m_qb[f] == t) begin m_qb[f] = 0; m_vb[f] = int'(bc_val); end
      end
   endtask

   // Inputs are set just after the falling edge; compare mid-low phase.
   task automatic cyc();
      #5;
      if (rst_n) compare();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      flush = 0; dsp_valid = 0; bc_valid = 0;
   endtask

   task automatic dsp(int op, int at, int av, int bt, int bv, int dst);
      dsp_valid = 1;
      dsp_op = OW'(op);
      dsp_a_tag = TW'(at); dsp_a_val = DW'(av);
      dsp_b_tag = TW'(bt); dsp_b_val = DW'(bv);
      dsp_dst = TW'(dst);
   endtask

   task automatic bcast(int t, int v);
      bc_valid = 1; bc_tag = TW'(t); bc_val = DW'(v);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      idle();
      for (int k = 0; k < 3; k++) cyc();
      rst_n = 1;

      // R1: empty after reset
      cur_req = "R1";
      idle(); cyc();

      // R3: both sources present, offered the next cycle; R9 hold while not accepted
      cur_req = "R3";
      iss_ready = 0;
      dsp(5, 0, 100, 0, 200, 1); cyc();
      idle(); cur_req = "R9"; cyc(); cyc();
      iss_ready = 1; cyc(); cyc();

      // R5: one broadcast resolves both sources of one slot
      cur_req = "R5";
      iss_ready = 0;
      dsp(2, 3, 0, 3, 0, 4); cyc();
      idle(); cyc();
      bcast(3, 16'h1234); cyc();
      idle(); cyc();
      iss_ready = 1; cyc(); iss_ready = 0;
      // R5: sources resolved independently
      dsp(3, 5, 0, 6, 0, 2); cyc();
      idle(); bcast(5, 55); cyc();
      idle(); cyc();
      bcast(6, 66); cyc();
      idle(); cyc();
      cur_req = "R4";
      iss_ready = 1; cyc(); iss_ready = 0;

      // R7: invalid broadcast and zero-tag broadcast have no effect
      cur_req = "R7";
      dsp(7, 2, 0, 0, 9, 3); cyc();
      idle(); bc_valid = 0; bc_tag = 2; bc_val = 77; cyc();
      bcast(0, 88); cyc();
      idle(); cyc();
      bcast(2, 99); cyc();
      idle(); cyc();
      iss_ready = 1; cyc(); iss_ready = 0;

      // R6: broadcast in the same cycle as the matching dispatch
      cur_req = "R6";
      dsp(9, 4, 0, 0, 11, 5); bcast(4, 44); cyc();
      idle(); cyc();
      iss_ready = 1; cyc(); iss_ready = 0;

      // R2: fill all slots, then refuse
      cur_req = "R2";
      for (int k = 0; k < N; k++) begin
         dsp(k + 1, 7, 0, 0, k, k); cyc();
      end
      dsp(15, 0, 1, 0, 1, 6); cyc(); cyc();
      // R10: flush empties and blocks
      cur_req = "R10";
      flush = 1; cyc();
      flush = 0; dsp_valid = 0; cyc();
      dsp(1, 0, 3, 0, 4, 1); flush = 1; cyc();
      idle(); cyc();

      // R8: lowest ready slot wins and is overtaken by a lower one
      cur_req = "R8";
      dsp(1, 1, 0, 0, 10, 1); cyc();
      dsp(2, 2, 0, 0, 20, 2); cyc();
      dsp(3, 3, 0, 0, 30, 3); cyc();
      idle(); bcast(3, 300); cyc();
      bcast(2, 200); cyc();
      idle(); cyc();
      bcast(1, 100); cyc();
      idle(); cyc();
      iss_ready = 1; cyc(); cyc(); cyc(); cyc();
      iss_ready = 0;

      // Mixed traffic against the reference model
      cur_req = "R4";
      for (int k = 0; k < 3000; k++) begin
         idle();
         if ($urandom_range(1, 0) == 1)
            dsp($urandom_range(15, 0),
                ($urandom_range(1, 0) == 1) ? 0 : $urandom_range(7, 1), $urandom_range(65535, 0),
                ($urandom_range(1, 0) == 1) ? 0 : $urandom_range(7, 1), $urandom_range(65535, 0),
                $urandom_range(7, 0));
         if ($urandom_range(2, 0) != 0) bcast($urandom_range(7, 0), $urandom_range(65535, 0));
         iss_ready = ($urandom_range(2, 0) != 0);
         flush = ($urandom_range(63, 0) == 0);
         cyc();
      end
      idle(); iss_ready = 0; cyc();

      done = 1;
      summary();
      $finish;
   end

endmodule